// File: doc/BRIEF.md
# Four-Channel Byte DMA Sequencer

This block moves single bytes between peripherals and memory on behalf of four request lines. A CPU first sets up each channel through a small byte-wide register port. It loads a 16-bit start address and a 16-bit count word whose top two bits pick the direction of the move. It also sets a channel enable mask. When an enabled peripheral raises its request, the block asks the host for the bus with a hold request. Once the host grants the bus, the block runs one transfer per granted sequence for the most urgent enabled channel.

Each transfer takes two phases. The first is an address phase: the low address byte is driven directly, and the high byte appears on a separate output while a one-cycle strobe tells an outside latch to capture it. The second is a move phase, in which the memory and I/O strobes are active and the channel's acknowledge is held. A low ready input stretches the move phase. During the last transfer of a block, a terminal-count output is raised and the channel's sticky status bit is set. A mark output flags every 128th transfer, counted back from the end of the block. The CPU reads the status flags, and that read clears them.

Top module: `dmac_top`

## Requirements
- R1: Register port layout: with reg_addr[4]=0, bits [3:2] select the channel, bit 1 selects address (0) or count (1), and bit 0 selects the low (0) or high (1) byte. Writes load that byte on the clock edge, and reads return it combinationally on reg_rdata.
- R2: Fixed priority: among the enabled requests present at the edge that starts a transfer, the lowest-numbered channel is served. At most one dack bit is high at a time.
- R3: Writing reg_addr[4]=1 sets the enable mask from reg_wdata[3:0]. A request on a disabled channel raises no hold request and gets no acknowledge.
- R4: While no transfer is in progress, hrq equals the OR of the enabled requests seen at the previous edge. An address phase begins only after an edge at which hlda was high. hrq falls when a transfer ends with no enabled request left.
- R5: Each transfer is one address-phase cycle followed by one or more move-phase cycles. In the address phase adstb=1 and addr_hi carries address bits [15:8]. dack of the served channel is high in both phases, and addr_lo carries address bits [7:0].
- R6: Count bits [15:14] select the type. 01 asserts io_rd and mem_wr. 10 asserts mem_rd and io_wr. 00 (verify) and 11 (illegal) assert no strobe. Strobes are active only in the move phase.
- R7: While ready is low in the move phase, the phase repeats with dack, addr_lo and the strobes unchanged.
- R8: Each completed transfer adds 1 to the channel address and subtracts 1, modulo 2^14, from count bits [13:0]. Count bits [15:14] are kept.
- R9: tc is high in the move phase of a transfer whose count bits [13:0] are zero. The channel's status bit is set when that transfer completes.
- R10: mark is high in the move phase of a transfer whose count bits [6:0] are all ones.
- R11: A read with reg_addr[4]=1 returns status: bits [3:0] are the per-channel terminal-count flags, bit 4 is hrq, and the rest are zero. That read clears the flags on the following edge. A flag being set on the same edge wins. All flags are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on status read) |
| reg_addr | input | 5 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| req | input | 4 | Peripheral service requests |
| dack | output | 4 | Per-channel acknowledge |
| hrq | output | 1 | Bus hold request to host |
| hlda | input | 1 | Bus grant from host |
| ready | input | 1 | Move-phase wait control, low inserts waits |
| addr_lo | output | 8 | Low address byte |
| addr_hi | output | 8 | High address byte for external latch |
| adstb | output | 1 | Latch strobe for addr_hi |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| tc | output | 1 | Last transfer of block |
| mark | output | 1 | Every 128th transfer from block end |

## Verification
The hardest situation to reach from the ports is a mark pulse. It needs one channel to win arbitration many times in a row until its count reaches a value whose low seven bits are all ones. Competing channels, a wandering grant and wait cycles all get in the way. The stimulus gives the lowest-priority channel a count above 128 and sets the other channels to short counts that wrap to 0x3FFF, which is itself a mark point. It then runs long random phases of requests, grant and ready, while a bench model follows every completed transfer. The same model also predicts the sticky status flags, and these are compared through status reads at the end.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
// Shared types for the DMA sequencer.
// Assumes: the transfer type lives in the top two count bits.
package dmac_pkg;
    typedef enum logic [1:0] {
        XT_CHECK    = 2'b00,
        XT_TO_MEM   = 2'b01,
        XT_FROM_MEM = 2'b10,
        XT_BAD      = 2'b11
    } xtype_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_ADDR = 2'b01,
        SQ_MOVE = 2'b10
    } sq_state_t;
endpackage

// File: rtl/dmac_chan.sv
`timescale 1ns/1ps
// Per-channel address and count registers.
// Does: byte loads from the CPU, and advance after each completed transfer.
// Assumes: AW-DW <= DW; a CPU write in the same cycle as a step wins.
module dmac_chan #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 14,
    parameter int MW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_cnt,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] cnt_q,
    output logic          last,
    output logic          mark_pt
);
    localparam int HW = AW - DW;
    localparam logic [AW-1:0] ONE_A = 1;
    localparam logic [CW-1:0] ONE_C = 1;

    // Load bytes from the CPU or advance on a finished transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (wr_en) begin
            case ({wr_cnt, wr_hi})
                2'b00:   addr_q[DW-1:0]  <= wdata;
                2'b01:   addr_q[AW-1:DW] <= wdata[HW-1:0];
                2'b10:   cnt_q[DW-1:0]   <= wdata;
                default: cnt_q[AW-1:DW]  <= wdata[HW-1:0];
            endcase
        end else if (step) begin
            addr_q <= addr_q + ONE_A;
            cnt_q  <= {cnt_q[AW-1:CW], cnt_q[CW-1:0] - ONE_C};
        end
    end

    // Flag the final transfer and the periodic mark points.
    always_comb begin
        last    = (cnt_q[CW-1:0] == '0);
        mark_pt = &cnt_q[MW-1:0];
    end
endmodule

// File: rtl/dmac_prio.sv
`timescale 1ns/1ps
// Fixed-priority picker: the lowest set index wins.
// Assumes: req is already masked by the channel enables.
module dmac_prio #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest requester is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dmac_seq.sv
`timescale 1ns/1ps
// Transfer sequencer: bus request, address phase, move phase.
// Assumes: the grant is sampled each edge; ready is synchronous.
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_req,
    input  logic [IW-1:0] win,
    input  logic          hlda,
    input  logic          ready,
    output sq_state_t     st,
    output logic [IW-1:0] cur,
    output logic          hrq,
    output logic          done
);
    // Step through the phases and latch the served channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cur <= '0;
            hrq <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    hrq <= any_req;
                    if (hrq && hlda && any_req) begin
                        st  <= SQ_ADDR;
                        cur <= win;
                    end
                end
                SQ_ADDR: st <= SQ_MOVE;
                SQ_MOVE: begin
                    if (ready) begin
                        hrq <= any_req;
                        if (hlda && any_req) begin
                            st  <= SQ_ADDR;
                            cur <= win;
                        end else begin
                            st <= SQ_IDLE;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // A transfer completes on a ready move-phase cycle.
    assign done = (st == SQ_MOVE) && ready;
endmodule

// File: rtl/dmac_top.sv
`timescale 1ns/1ps
// Four-channel byte DMA sequencer top.
// Does: register port, enables, status flags, phase outputs.
// Assumes: RAW = log2(NCH) + 3; AW = 2*DW; NCH + 1 <= DW.
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int CW  = 14,
    parameter int MW  = 7,
    parameter int RAW = $clog2(NCH) + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] req,
    output logic [NCH-1:0] dack,
    output logic           hrq,
    input  logic           hlda,
    input  logic           ready,
    output logic [DW-1:0]  addr_lo,
    output logic [DW-1:0]  addr_hi,
    output logic           adstb,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           io_rd,
    output logic           io_wr,
    output logic           tc,
    output logic           mark
);
    localparam int IW = $clog2(NCH);

    logic [AW-1:0]  ch_addr [NCH];
    logic [AW-1:0]  ch_cnt  [NCH];
    logic [NCH-1:0] ch_last, ch_mark, ch_step, ch_wr;
    logic [NCH-1:0] en_q, tc_flags, tc_set;
    logic           any_req, done, in_addr, in_move, stat_sel;
    logic [IW-1:0]  win, cur;
    logic [IW-1:0]  rd_ch;
    logic [AW-1:0]  rd_word, cur_addr;
    sq_state_t      st;
    xtype_t         xt;

    assign stat_sel = reg_addr[RAW-1];
    assign rd_ch    = reg_addr[RAW-2:2];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            assign ch_wr[g]   = reg_wr && !stat_sel && (rd_ch == IW'(g));
            assign ch_step[g] = done && (cur == IW'(g));
            assign tc_set[g]  = ch_step[g] && ch_last[g];
            dmac_chan #(.AW(AW), .DW(DW), .CW(CW), .MW(MW)) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (ch_wr[g]),
                .wr_cnt (reg_addr[1]),
                .wr_hi  (reg_addr[0]),
                .wdata  (reg_wdata),
                .step   (ch_step[g]),
                .addr_q (ch_addr[g]),
                .cnt_q  (ch_cnt[g]),
                .last   (ch_last[g]),
                .mark_pt(ch_mark[g])
            );
        end
    endgenerate

    dmac_prio #(.N(NCH), .IW(IW)) u_prio (
        .req(req & en_q),
        .any(any_req),
        .idx(win)
    );

    dmac_seq #(.IW(IW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .any_req(any_req),
        .win    (win),
        .hlda   (hlda),
        .ready  (ready),
        .st     (st),
        .cur    (cur),
        .hrq    (hrq),
        .done   (done)
    );

    // Hold the enable mask and the sticky terminal-count flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            tc_flags <= '0;
        end else begin
            if (reg_wr && stat_sel) en_q <= reg_wdata[NCH-1:0];
            tc_flags <= ((reg_rd && stat_sel) ? '0 : tc_flags) | tc_set;
        end
    end

    // Return the selected register byte or the status byte.
    always_comb begin
        rd_word = reg_addr[1] ? ch_cnt[rd_ch] : ch_addr[rd_ch];
        if (stat_sel)
            reg_rdata = DW'({hrq, tc_flags});
        else if (reg_addr[0])
            reg_rdata = DW'(rd_word[AW-1:DW]);
        else
            reg_rdata = rd_word[DW-1:0];
    end

    // Drive the phase outputs for the served channel.
    always_comb begin
        in_addr  = (st == SQ_ADDR);
        in_move  = (st == SQ_MOVE);
        cur_addr = ch_addr[cur];
        xt       = xtype_t'(ch_cnt[cur][AW-1:AW-2]);
        dack     = (in_addr || in_move) ? (NCH'(1) << cur) : '0;
        addr_lo  = (in_addr || in_move) ? cur_addr[DW-1:0] : '0;
        addr_hi  = in_addr ? DW'(cur_addr[AW-1:DW]) : '0;
        adstb    = in_addr;
        mem_wr   = in_move && (xt == XT_TO_MEM);
        io_rd    = in_move && (xt == XT_TO_MEM);
        mem_rd   = in_move && (xt == XT_FROM_MEM);
        io_wr    = in_move && (xt == XT_FROM_MEM);
        tc       = in_move && ch_last[cur];
        mark     = in_move && ch_mark[cur];
    end
endmodule

// File: rtl/dmac_chk.sv
`timescale 1ns/1ps
// Protocol checker for dmac_top, attached by bind.
// Assumes: the same reset and clock as the block.
module dmac_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] dack,
    input logic           hrq,
    input logic           hlda,
    input logic           ready,
    input logic           adstb,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr,
    input logic           tc,
    input logic [DW-1:0]  addr_lo
);
    // R2
    dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R6
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || io_rd || io_wr) |-> ((|dack) && hrq && !adstb
            && !(mem_rd && mem_wr) && !(io_rd && io_wr)));

    // R5
    addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |=> (!adstb && dack == $past(dack)));

    // R4
    grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |-> ($past(hlda) && hrq));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dack) && !adstb && !ready) |=>
            ($stable(dack) && $stable(addr_lo) && !adstb
             && $stable(mem_rd) && $stable(mem_wr)));

    // R9
    tc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> ((|dack) && !adstb));
endmodule

bind dmac_top dmac_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dack   (dack),
    .hrq    (hrq),
    .hlda   (hlda),
    .ready  (ready),
    .adstb  (adstb),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .tc     (tc),
    .addr_lo(addr_lo)
);

// File: tb/dmac_top_tb.sv
`timescale 1ns/1ps
// Bench for dmac_top: directed cases plus seeded random runs
// against a transfer-level model.
module dmac_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [3:0] req = '0, dack;
    logic       hrq, hlda = 1'b0, ready = 1'b1;
    logic [7:0] addr_lo, addr_hi;
    logic       adstb, mem_rd, mem_wr, io_rd, io_wr, tc, mark;

    int n_chk = 0, n_bad = 0;
    bit ended = 0;

    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [3:0]  m_tc = '0, en_m = '0, req_prev = '0;
    logic        hlda_prev = 1'b0;

    always #2.5 clk = ~clk;

    dmac_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req(req), .dack(dack), .hrq(hrq), .hlda(hlda), .ready(ready),
        .addr_lo(addr_lo), .addr_hi(addr_hi), .adstb(adstb),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .tc(tc), .mark(mark)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return 4;
    endfunction

    function automatic logic [3:0] exp_strobes(input logic [1:0] ty);
        // order {mem_rd, mem_wr, io_rd, io_wr}
        if (ty == 2'b01) return 4'b0110;
        if (ty == 2'b10) return 4'b1001;
        return 4'b0000;
    endfunction

    task automatic cpu_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a[4]) en_m = d[3:0];
    endtask

    task automatic cpu_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic setup_ch(input int ch, input logic [15:0] a, input logic [15:0] c);
        cpu_wr({1'b0, 2'(ch), 2'b00}, a[7:0]);
        cpu_wr({1'b0, 2'(ch), 2'b01}, a[15:8]);
        cpu_wr({1'b0, 2'(ch), 2'b10}, c[7:0]);
        cpu_wr({1'b0, 2'(ch), 2'b11}, c[15:8]);
        m_addr[ch] = a; m_cnt[ch] = c;
    endtask

    // Per-cycle monitor and stimulus; quiet drains with no requests.
    task automatic run(input int ncyc, input logic [3:0] rmask, input bit quiet);
        req_prev = req; hlda_prev = hlda;
        for (int c = 0; c < ncyc; c++) begin
            int w, ch;
            logic [3:0] rn;
            @(negedge clk);
            if (adstb) begin
                w = lowest(req_prev & en_m);
                chk(w < 4 && dack == (4'b1 << w), "R2 winner", dack, 32'(w));
                chk(hlda_prev == 1'b1, "R4 grant before addr phase", hlda_prev, 1);
                if (w < 4) chk(addr_hi == m_addr[w][15:8], "R5 addr_hi", addr_hi, m_addr[w][15:8]);
            end
            if (dack != 0) begin
                ch = lowest(dack);
                chk(addr_lo == m_addr[ch][7:0], "R5 addr_lo", addr_lo, m_addr[ch][7:0]);
            end
            if (dack != 0 && !adstb) begin
                ch = lowest(dack);
                chk({mem_rd, mem_wr, io_rd, io_wr} == exp_strobes(m_cnt[ch][15:14]),
                    "R6 strobes", {mem_rd, mem_wr, io_rd, io_wr}, exp_strobes(m_cnt[ch][15:14]));
                chk(tc == (m_cnt[ch][13:0] == 0), "R9 tc", tc, m_cnt[ch][13:0] == 0);
                chk(mark == (&m_cnt[ch][6:0]), "R10 mark", mark, &m_cnt[ch][6:0]);
            end
            if (dack == 0) begin
                chk(hrq == |(req_prev & en_m), "R4 R3 hrq idle", hrq, |(req_prev & en_m));
                chk({mem_rd, mem_wr, io_rd, io_wr, tc, mark, adstb} == 0,
                    "R6 no strobes idle", {mem_rd, mem_wr, io_rd, io_wr, tc, mark, adstb}, 0);
            end
            if (quiet) begin
                rn = '0; hlda = 1'b0; ready = 1'b1;
            end else begin
                rn = 4'($urandom) & rmask;
                hlda = ($urandom % 8) != 0;
                ready = ($urandom % 4) != 0;
            end
            req = rn;
            if (dack != 0 && !adstb && ready) begin
                ch = lowest(dack);
                if (m_cnt[ch][13:0] == 0) m_tc[ch] = 1'b1;
                m_addr[ch] = m_addr[ch] + 16'd1;
                m_cnt[ch][13:0] = m_cnt[ch][13:0] - 14'd1;
            end
            req_prev = rn; hlda_prev = hlda;
        end
    endtask

    task automatic check_regs();
        logic [7:0] d;
        for (int ch = 0; ch < 4; ch++) begin
            cpu_rd({1'b0, 2'(ch), 2'b00}, d); chk(d == m_addr[ch][7:0],  "R8 addr lo", d, m_addr[ch][7:0]);
            cpu_rd({1'b0, 2'(ch), 2'b01}, d); chk(d == m_addr[ch][15:8], "R8 addr hi", d, m_addr[ch][15:8]);
            cpu_rd({1'b0, 2'(ch), 2'b10}, d); chk(d == m_cnt[ch][7:0],   "R8 cnt lo", d, m_cnt[ch][7:0]);
            cpu_rd({1'b0, 2'(ch), 2'b11}, d); chk(d == m_cnt[ch][15:8],  "R8 cnt hi", d, m_cnt[ch][15:8]);
        end
        cpu_rd(5'h10, d);
        chk(d == {4'b0, m_tc}, "R11 status flags", d, {4'b0, m_tc});
        m_tc = '0;
        cpu_rd(5'h10, d);
        chk(d == 8'h00, "R11 cleared by read", d, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!ended) begin
            ended = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int k;
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R11, R4)
        chk(hrq == 0 && dack == 0 && adstb == 0, "R4 reset outputs", {hrq, dack, adstb}, 0);
        cpu_rd(5'h10, d);
        chk(d == 0, "R11 reset status", d, 0);

        // R1 register load and readback
        setup_ch(2, 16'hBEEF, 16'h4005);
        cpu_rd(5'b0_10_00, d); chk(d == 8'hEF, "R1 ch2 addr lo", d, 8'hEF);
        cpu_rd(5'b0_10_01, d); chk(d == 8'hBE, "R1 ch2 addr hi", d, 8'hBE);
        cpu_rd(5'b0_10_11, d); chk(d == 8'h40, "R1 ch2 cnt hi", d, 8'h40);

        // R3 all channels disabled: requests ignored
        for (int ch = 0; ch < 4; ch++) setup_ch(ch, 16'(ch * 16'h1111), 16'h4003);
        cpu_wr(5'h10, 8'h00);
        run(40, 4'hF, 0);
        run(4, 4'h0, 1);
        chk(dack == 0, "R3 no acknowledge when disabled", dack, 0);
        check_regs();

        // R7 directed stall on channel 1, one write-to-memory transfer
        setup_ch(1, 16'h1230, 16'h4002);
        cpu_wr(5'h10, 8'h02);
        @(negedge clk); req = 4'b0010; hlda = 1'b1; ready = 1'b0;
        k = 0;
        while (!(dack != 0 && !adstb) && k < 10) begin @(negedge clk); k++; end
        for (int i = 0; i < 5; i++) begin
            chk(mem_wr && io_rd && addr_lo == 8'h30 && dack == 4'b0010,
                "R7 stretched move phase", {mem_wr, io_rd, addr_lo, dack}, {2'b11, 8'h30, 4'b0010});
            @(negedge clk);
        end
        ready = 1'b1; req = '0; hlda = 1'b0;
        @(negedge clk);
        chk(hrq == 0 && dack == 0, "R4 hrq drops with no request", {hrq, dack}, 0);
        m_addr[1] = 16'h1231; m_cnt[1] = 16'h4001;
        check_regs();

        // Random rounds: ch3 gets a long block for mark coverage
        for (int r = 0; r < 2; r++) begin
            for (int ch = 0; ch < 3; ch++)
                setup_ch(ch, 16'($urandom), {2'($urandom), 14'($urandom % 6)});
            setup_ch(3, 16'($urandom), {2'($urandom), 14'd140});
            cpu_wr(5'h10, (r == 0) ? 8'h0F : {4'h0, 4'($urandom) | 4'b1000});
            run(3000, 4'hF, 0);
            run(20, 4'h0, 1);
            check_regs();
        end

        // R9/R11 directed single-transfer block on channel 0
        setup_ch(0, 16'h00FF, 16'h8000);
        cpu_wr(5'h10, 8'h01);
        run(12, 4'h1, 0);
        run(20, 4'h0, 1);
        check_regs();

        ended = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule